// File: doc/BRIEF.md
# Three-Wire Serial Register Target

This block sits between a three-wire serial host link and a register bank. The link has an active-high transfer enable, a serial clock and one data line. The data line appears here as a separate input, output and output enable, for an I/O cell at the chip edge. All three link signals are oversampled by the fast system clock. Every transfer opens with an 8-bit command byte, sent least significant bit first. The command names one of two register spaces: a small clock space, or a 31-byte scratch RAM. It also gives a location and says whether data goes in or out. Data bytes then follow, least significant bit first. Input bits are taken on rising serial clock edges. Output bits change on falling edges.

Location 31 in either space starts a burst. A burst begins at location 0 and steps through successive locations for as long as the enable stays high. RAM burst bytes are written one at a time as each byte completes. Clock burst bytes are held in a staging store. They are committed together only when all eight have arrived. The block owns the write-protect bit of the control register itself. It turns every transfer into single-cycle read or write strobes toward the bank, with a location and a space select. Read data comes back from the bank a fixed number of cycles after the read strobe.

Top module: `tw_serial_target`

## Requirements
- R1: Command encoding, received LSB first on rising serial clock edges: bit 0 = 1 means read and 0 means write; bits 5:1 are the location; bit 6 = 0 selects the clock space and 1 selects the RAM space; bit 7 must be 1, or no write of that transfer takes effect.
- R2: In a read, bit 0 of the first data byte is driven on the first falling serial clock edge after the eighth command bit. Each later bit follows on a later falling edge, LSB first. The output enable drops after every rising serial clock edge.
- R3: While the transfer enable is low, the output enable is 0. Dropping the enable in the middle of a byte ends the transfer, and the partial byte is not written.
- R4: A single-byte write stores exactly one byte at the named location. Further serial clock cycles before the enable falls are ignored.
- R5: In a single-byte read, further serial clock cycles while the enable stays high send the same byte again.
- R6: Location 31 in the RAM space is a burst over RAM locations 0 to 30. A write commits each completed byte at once, even if fewer than 31 arrive. A read returns successive locations.
- R7: Location 31 in the clock space is a burst over clock locations 0 to 7, where 7 is the control register. A write takes effect only after all eight bytes have arrived, and only if write protect was clear when the command ended. Otherwise none of the eight changes. Clock location 8 is never touched by a burst.
- R8: Clock location 7 is the control register. Bit 7 is write protect and bits 6:0 always read 0. A single write to it is always accepted. While write protect is 1, every other write is blocked. Reset sets write protect.
- R9: Clock locations 9 to 30 have no storage. They read back 0, and writes to them produce no bank strobe.
- R10: After reset the output enable is 0 and neither bank strobe is active.
- R11: Each bank access is a one-cycle strobe. A single write gives exactly one write strobe. A single read gives exactly one read strobe, and the data is taken RD_LAT cycles after that strobe. Read and write strobes never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_en | input | 1 | Transfer enable from the host, active high |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data line as seen at the pad |
| ser_dout | output | 1 | Serial data to drive onto the line |
| ser_doe | output | 1 | Output enable for the data line pad |
| bank_rd | output | 1 | One-cycle read strobe to the register bank |
| bank_wr | output | 1 | One-cycle write strobe to the register bank |
| bank_ram | output | 1 | Space select: 1 for RAM, 0 for clock |
| bank_addr | output | AW | Location within the selected space |
| bank_wdata | output | DW | Write data |
| bank_rdata | input | DW | Read data, valid RD_LAT cycles after bank_rd |

## Verification
The bench builds the block with RD_LAT set to 2 and keeps two synchronizer stages. This exercises the multi-stage read-return pipe. It also shows that data fetched for the next byte lands before the next falling serial edge. The serial clock half period is 20 system cycles, so every burst step has to fit the fetch-ahead into that gap. The default sizes (31 RAM bytes, an 8-byte clock burst, a 9-entry clock space) let the bench reach the RAM burst bound, the staged clock commit and its write-protect and partial-burst cases, and the clock locations with no storage.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_DONE
  } tw_state_e;

  // Field order follows the command byte, bit 7 down to bit 0.
  typedef struct packed {
    logic       wr_ok;
    logic       ram;
    logic [4:0] addr;
    logic       rd;
  } tw_cmd_t;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign lvl_o = stg[STAGES-1];
endmodule

// File: rtl/tw_rdpipe.sv
module tw_rdpipe #(
  parameter int LAT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic vld_o
);
  if (LAT == 0) begin : g_zero
    assign vld_o = req_i;
  end else begin : g_pipe
    logic [LAT-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh <= '0;
      end else begin
        sh[0] <= req_i;
        for (int i = 1; i < LAT; i++) sh[i] <= sh[i-1];
      end
    end
    assign vld_o = sh[LAT-1];
  end
endmodule

// File: rtl/tw_stage_buf.sv
module tw_stage_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tw_serial_target.sv
module tw_serial_target #(
  parameter int DW          = 8,
  parameter int AW          = 5,
  parameter int CLK_REGS    = 9,
  parameter int CTRL_LOC    = 7,
  parameter int CLK_BURST   = 8,
  parameter int RAM_WORDS   = 31,
  parameter int SYNC_STAGES = 2,
  parameter int RD_LAT      = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer_en,
  input  logic          ser_clk,
  input  logic          ser_din,
  output logic          ser_dout,
  output logic          ser_doe,
  output logic          bank_rd,
  output logic          bank_wr,
  output logic          bank_ram,
  output logic [AW-1:0] bank_addr,
  output logic [DW-1:0] bank_wdata,
  input  logic [DW-1:0] bank_rdata
);
  import tw_pkg::*;

  localparam int            BW         = $clog2(DW);
  localparam int            SW         = $clog2(CLK_BURST);
  localparam logic [BW-1:0] BIT_LAST   = BW'(DW - 1);
  localparam logic [AW-1:0] BURST_LOC  = '1;
  localparam logic [AW-1:0] CTRL_A     = AW'(CTRL_LOC);
  localparam logic [AW-1:0] CLK_TOP    = AW'(CLK_REGS - 1);
  localparam logic [AW-1:0] CLK_LAST   = AW'(CLK_BURST - 1);
  localparam logic [AW-1:0] RAM_LAST   = AW'(RAM_WORDS - 1);
  localparam logic [SW-1:0] STG_LAST   = SW'(CLK_BURST - 1);

  // input oversampling
  logic [2:0] lvl;
  logic       ce_s, sclk_s, dio_s, sclk_prev, sclk_r, sclk_f;

  tw_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk(clk), .rst(rst),
    .async_i({ser_din, ser_clk, xfer_en}),
    .lvl_o(lvl)
  );

  assign ce_s   = lvl[0];
  assign sclk_s = lvl[1];
  assign dio_s  = lvl[2];

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk_s;
  end

  assign sclk_r = sclk_s & ~sclk_prev;
  assign sclk_f = ~sclk_s & sclk_prev;

  // state
  tw_state_e     state;
  logic [DW-2:0] shreg;
  logic [DW-1:0] nxt_byte, txbuf, wdata_q;
  logic [BW-1:0] bitcnt;
  logic [AW-1:0] cur_addr, nxt_addr, fetch_addr, addr_q;
  logic          sp_ram_q, wr_ok_q, burst_q, burst_wp_q, wp_q;
  logic          dout_q, oe_q, rd_q, wr_q, ram_q, fetch_go, rd_vld;
  logic          stg_we;
  logic [SW-1:0] stg_waddr, cm_idx, cm_ridx;
  logic [DW-1:0] stg_wdata, stg_rdata;
  logic          cm_act, cm_rvld;
  tw_cmd_t       cmd_in;
  logic          is_burst;

  assign nxt_byte = {dio_s, shreg};
  assign cmd_in   = tw_cmd_t'(nxt_byte[7:0]);
  assign is_burst = (cmd_in.addr == BURST_LOC);
  assign nxt_addr = (cur_addr == (sp_ram_q ? RAM_LAST : CLK_LAST)) ? '0 : cur_addr + 1'b1;

  function automatic logic has_store(input logic sp, input logic [AW-1:0] a);
    if (sp) return (a <= RAM_LAST);
    return (a <= CLK_TOP) && (a != CTRL_A);
  endfunction

  tw_rdpipe #(.LAT(RD_LAT)) u_rdpipe (
    .clk(clk), .rst(rst), .req_i(rd_q), .vld_o(rd_vld)
  );

  tw_stage_buf #(.DW(DW), .DEPTH(CLK_BURST), .IW(SW)) u_stage (
    .clk(clk), .we(stg_we), .waddr(stg_waddr), .wdata(stg_wdata),
    .raddr(cm_idx), .rdata(stg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      bitcnt     <= '0;
      cur_addr   <= '0;
      sp_ram_q   <= 1'b0;
      wr_ok_q    <= 1'b0;
      burst_q    <= 1'b0;
      burst_wp_q <= 1'b0;
      wp_q       <= 1'b1;
      txbuf      <= '0;
      dout_q     <= 1'b0;
      oe_q       <= 1'b0;
      rd_q       <= 1'b0;
      wr_q       <= 1'b0;
      addr_q     <= '0;
      ram_q      <= 1'b0;
      wdata_q    <= '0;
      fetch_go   <= 1'b0;
      fetch_addr <= '0;
      stg_we     <= 1'b0;
      stg_waddr  <= '0;
      stg_wdata  <= '0;
      cm_act     <= 1'b0;
      cm_idx     <= '0;
      cm_rvld    <= 1'b0;
      cm_ridx    <= '0;
    end else begin
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      stg_we   <= 1'b0;
      fetch_go <= 1'b0;

      // read return and fetch-ahead
      if (rd_vld) txbuf <= bank_rdata;
      if (fetch_go) begin
        if (has_store(sp_ram_q, fetch_addr)) begin
          rd_q   <= 1'b1;
          addr_q <= fetch_addr;
          ram_q  <= sp_ram_q;
        end else if (!sp_ram_q && fetch_addr == CTRL_A) begin
          txbuf <= {wp_q, {(DW-1){1'b0}}};
        end else begin
          txbuf <= '0;
        end
      end

      // staged clock-burst commit, control byte last
      cm_rvld <= cm_act;
      cm_ridx <= cm_idx;
      if (cm_act) begin
        cm_idx <= cm_idx + 1'b1;
        if (cm_idx == STG_LAST) cm_act <= 1'b0;
      end
      if (cm_rvld) begin
        if (AW'(cm_ridx) == CTRL_A) begin
          wp_q <= stg_rdata[DW-1];
        end else begin
          wr_q    <= 1'b1;
          addr_q  <= AW'(cm_ridx);
          ram_q   <= 1'b0;
          wdata_q <= stg_rdata;
        end
      end

      // serial protocol
      if (!ce_s) begin
        state <= ST_IDLE;
        oe_q  <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            state  <= ST_CMD;
            bitcnt <= '0;
          end
          ST_CMD: if (sclk_r) begin
            shreg  <= nxt_byte[DW-1:1];
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == BIT_LAST) begin
              wr_ok_q    <= cmd_in.wr_ok;
              sp_ram_q   <= cmd_in.ram;
              burst_q    <= is_burst;
              burst_wp_q <= wp_q;
              cur_addr   <= is_burst ? '0 : cmd_in.addr;
              bitcnt     <= '0;
              if (cmd_in.rd) begin
                state      <= ST_RD;
                fetch_go   <= 1'b1;
                fetch_addr <= is_burst ? '0 : cmd_in.addr;
              end else begin
                state <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (sclk_f) begin
              oe_q   <= 1'b1;
              dout_q <= txbuf[bitcnt];
            end
            if (sclk_r) begin
              oe_q   <= 1'b0;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == BIT_LAST && burst_q) begin
                cur_addr   <= nxt_addr;
                fetch_go   <= 1'b1;
                fetch_addr <= nxt_addr;
              end
            end
          end
          ST_WR: if (sclk_r) begin
            shreg  <= nxt_byte[DW-1:1];
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == BIT_LAST) begin
              if (!burst_q) begin
                state <= ST_DONE;
                if (wr_ok_q) begin
                  if (!sp_ram_q && cur_addr == CTRL_A) begin
                    wp_q <= nxt_byte[DW-1];
                  end else if (!wp_q && has_store(sp_ram_q, cur_addr)) begin
                    wr_q    <= 1'b1;
                    addr_q  <= cur_addr;
                    ram_q   <= sp_ram_q;
                    wdata_q <= nxt_byte;
                  end
                end
              end else if (sp_ram_q) begin
                if (wr_ok_q && !wp_q) begin
                  wr_q    <= 1'b1;
                  addr_q  <= cur_addr;
                  ram_q   <= 1'b1;
                  wdata_q <= nxt_byte;
                end
                if (cur_addr == RAM_LAST) state <= ST_DONE;
                else                      cur_addr <= cur_addr + 1'b1;
              end else begin
                stg_we    <= 1'b1;
                stg_waddr <= cur_addr[SW-1:0];
                stg_wdata <= nxt_byte;
                if (cur_addr == CLK_LAST) begin
                  state <= ST_DONE;
                  if (wr_ok_q && !burst_wp_q) begin
                    cm_act <= 1'b1;
                    cm_idx <= '0;
                  end
                end else begin
                  cur_addr <= cur_addr + 1'b1;
                end
              end
            end
          end
          ST_DONE: ;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign ser_dout   = dout_q;
  assign ser_doe    = oe_q;
  assign bank_rd    = rd_q;
  assign bank_wr    = wr_q;
  assign bank_ram   = ram_q;
  assign bank_addr  = addr_q;
  assign bank_wdata = wdata_q;
endmodule

// File: rtl/tw_check.sv
module tw_check #(
  parameter int AW        = 5,
  parameter int CLK_REGS  = 9,
  parameter int CTRL_LOC  = 7,
  parameter int RAM_WORDS = 31
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_s,
  input logic          sclk_r,
  input logic          ser_doe,
  input logic          bank_rd,
  input logic          bank_wr,
  input logic          bank_ram,
  input logic [AW-1:0] bank_addr,
  input logic          wp
);
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
    rst |=> (!ser_doe && !bank_rd && !bank_wr)); // R10

  AST_OE_OFF_CE_LOW: assert property (@(posedge clk) disable iff (rst)
    !ce_s |=> !ser_doe); // R3

  AST_OE_DROP_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    sclk_r |=> !ser_doe); // R2

  AST_WR_NEEDS_WP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    bank_wr |-> !wp); // R8

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bank_rd && bank_wr)); // R11

  AST_WR_HAS_STORE: assert property (@(posedge clk) disable iff (rst)
    bank_wr |-> (bank_ram ? (int'(bank_addr) < RAM_WORDS)
                          : (int'(bank_addr) < CLK_REGS && int'(bank_addr) != CTRL_LOC))); // R9

  AST_RD_HAS_STORE: assert property (@(posedge clk) disable iff (rst)
    bank_rd |-> (bank_ram ? (int'(bank_addr) < RAM_WORDS)
                          : (int'(bank_addr) < CLK_REGS && int'(bank_addr) != CTRL_LOC))); // R9
endmodule

bind tw_serial_target tw_check #(
  .AW(AW), .CLK_REGS(CLK_REGS), .CTRL_LOC(CTRL_LOC), .RAM_WORDS(RAM_WORDS)
) u_tw_check (
  .clk(clk), .rst(rst), .ce_s(ce_s), .sclk_r(sclk_r), .ser_doe(ser_doe),
  .bank_rd(bank_rd), .bank_wr(bank_wr), .bank_ram(bank_ram),
  .bank_addr(bank_addr), .wp(wp_q)
);

// File: tb/test_tw_serial_target.sv
module test_tw_serial_target;
  localparam int HP = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xfer_en = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
  logic       ser_dout, ser_doe, bank_rd, bank_wr, bank_ram;
  logic [4:0] bank_addr;
  logic [7:0] bank_wdata, bank_rdata;

  int nchk = 0, nfail = 0, nwr = 0, nrd = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tw_serial_target #(.RD_LAT(2)) i_tw_serial_target (
    .clk(clk), .rst(rst), .xfer_en(xfer_en), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_dout(ser_dout), .ser_doe(ser_doe), .bank_rd(bank_rd), .bank_wr(bank_wr),
    .bank_ram(bank_ram), .bank_addr(bank_addr), .bank_wdata(bank_wdata),
    .bank_rdata(bank_rdata)
  );

  // register bank model with two-cycle read return
  logic [7:0] clk_mem [32];
  logic [7:0] ram_mem [32];
  logic [7:0] rd_p1, rd_p2;
  initial begin
    for (int i = 0; i < 32; i++) begin
      clk_mem[i] = 8'h10 + 8'(i);
      ram_mem[i] = 8'h40 + 8'(i);
    end
  end
  always @(posedge clk) begin
    if (bank_wr) begin
      if (bank_ram) ram_mem[bank_addr] <= bank_wdata;
      else          clk_mem[bank_addr] <= bank_wdata;
      nwr <= nwr + 1;
    end
    if (bank_rd) nrd <= nrd + 1;
    rd_p1 <= bank_ram ? ram_mem[bank_addr] : clk_mem[bank_addr];
    rd_p2 <= rd_p1;
  end
  assign bank_rdata = rd_p2;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ce_on();
    ser_clk = 1'b0; tick(HP); xfer_en = 1'b1; tick(HP);
  endtask

  task automatic ce_off();
    tick(HP); xfer_en = 1'b0; tick(HP);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      ser_din = b[i]; tick(HP); ser_clk = 1'b1; tick(HP); ser_clk = 1'b0;
    end
  endtask

  // one byte out of the target; checks the output enable around each edge
  task automatic get_byte(output logic [7:0] b, output logic oe_ok);
    oe_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(HP);
      b[i] = ser_dout;
      if (!ser_doe) oe_ok = 1'b0;
      ser_clk = 1'b1; tick(HP/2);
      if (ser_doe) oe_ok = 1'b0;
      tick(HP/2); ser_clk = 1'b0;
    end
  endtask

  function automatic logic [7:0] cmd(input logic ok, input logic ram, input logic [4:0] a, input logic rd);
    return {ok, ram, a, rd};
  endfunction

  task automatic wr1(input logic ram, input logic [4:0] a, input logic [7:0] d);
    ce_on(); put_bits(cmd(1, ram, a, 0), 8); put_bits(d, 8); ce_off();
  endtask

  task automatic rd1(input logic ram, input logic [4:0] a, output logic [7:0] d);
    logic ok;
    ce_on(); put_bits(cmd(1, ram, a, 1), 8); get_byte(d, ok); ce_off();
    chk("R2 enable around edges", {7'b0, ok}, 8'h01);
  endtask

  // {ram, location, write data, expected read}
  localparam logic [21:0] VEC [8] = '{
    {1'b0, 5'd0,  8'h45, 8'h45},
    {1'b0, 5'd3,  8'h28, 8'h28},
    {1'b0, 5'd6,  8'h99, 8'h99},
    {1'b0, 5'd8,  8'hA5, 8'hA5},
    {1'b1, 5'd0,  8'h11, 8'h11},
    {1'b1, 5'd30, 8'hEE, 8'hEE},
    {1'b0, 5'd12, 8'h77, 8'h00},
    {1'b0, 5'd30, 8'h5A, 8'h00}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog R10 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    logic ok;
    int w0, r0;
    tick(5); rst = 1'b0; tick(3);

    // R10 reset state
    chk("R10 oe after reset", {7'b0, ser_doe}, 8'h00);
    chk("R10 strobes after reset", {6'b0, bank_rd, bank_wr}, 8'h00);
    rd1(0, 5'd7, d); chk("R8 write protect set by reset", d, 8'h80);
    wr1(0, 5'd7, 8'h7F);
    rd1(0, 5'd7, d); chk("R8 control low bits read 0", d, 8'h00);

    // R1 R4 R9 table of single writes and readbacks
    foreach (VEC[k]) begin
      wr1(VEC[k][21], VEC[k][20:16], VEC[k][15:8]);
      rd1(VEC[k][21], VEC[k][20:16], d);
      if (VEC[k][7:0] == 8'h00) chk("R9 no storage reads 0", d, VEC[k][7:0]);
      else                      chk("R1 R4 single write readback", d, VEC[k][7:0]);
    end

    // R11 strobe counts; R9 no strobe for empty location
    w0 = nwr; wr1(1, 5'd20, 8'h33); chk("R11 one write strobe", 8'(nwr - w0), 8'd1);
    r0 = nrd; rd1(1, 5'd20, d);     chk("R11 one read strobe", 8'(nrd - r0), 8'd1);
    chk("R11 read data", d, 8'h33);
    w0 = nwr; wr1(0, 5'd12, 8'h44); chk("R9 no write strobe", 8'(nwr - w0), 8'd0);

    // R8 write protect
    wr1(0, 5'd7, 8'hFF);
    rd1(0, 5'd7, d); chk("R8 control reads only bit 7", d, 8'h80);
    wr1(1, 5'd5, 8'h3C);
    rd1(1, 5'd5, d); chk("R8 protected RAM write blocked", d, 8'h45);
    wr1(0, 5'd2, 8'h3C);
    rd1(0, 5'd2, d); chk("R8 protected clock write blocked", d, 8'h12);
    wr1(0, 5'd7, 8'h00);

    // R1 bit 7 clear disables the write
    ce_on(); put_bits(cmd(0, 1, 5'd5, 0), 8); put_bits(8'h99, 8); ce_off();
    rd1(1, 5'd5, d); chk("R1 must-be-one bit clear", d, 8'h45);

    // R4 extra cycles after a single write
    ce_on(); put_bits(cmd(1, 1, 5'd10, 0), 8); put_bits(8'h5A, 8); put_bits(8'hC3, 8); ce_off();
    rd1(1, 5'd10, d); chk("R4 written byte", d, 8'h5A);
    rd1(1, 5'd11, d); chk("R4 extra cycles ignored", d, 8'h4B);

    // R5 single read repeats its byte
    ce_on(); put_bits(cmd(1, 1, 5'd10, 1), 8);
    get_byte(d, ok); get_byte(d2, ok); ce_off();
    chk("R5 first byte", d, 8'h5A);
    chk("R5 repeated byte", d2, 8'h5A);

    // R3 abort mid write and mid read
    ce_on(); put_bits(cmd(1, 1, 5'd12, 0), 8); put_bits(8'hFF, 4); ce_off();
    rd1(1, 5'd12, d); chk("R3 partial byte not written", d, 8'h4C);
    ce_on(); put_bits(cmd(1, 1, 5'd10, 1), 8); tick(HP);
    chk("R2 driven after first fall", {7'b0, ser_doe}, 8'h01);
    chk("R2 bit 0 first", {7'b0, ser_dout}, 8'h00);
    xfer_en = 1'b0; tick(10);
    chk("R3 enable low releases line", {7'b0, ser_doe}, 8'h00);
    tick(HP);

    // R6 RAM burst, partial write then read
    ce_on(); put_bits(8'hFE, 8); put_bits(8'hA0, 8); put_bits(8'hA1, 8); put_bits(8'hA2, 8); ce_off();
    rd1(1, 5'd2, d); chk("R6 partial burst committed", d, 8'hA2);
    ce_on(); put_bits(8'hFF, 8);
    get_byte(d, ok);  chk("R6 burst read loc 0", d, 8'hA0);
    get_byte(d, ok);  chk("R6 burst read loc 1", d, 8'hA1);
    get_byte(d, ok);  chk("R6 burst read loc 2", d, 8'hA2);
    get_byte(d, ok);  chk("R6 burst read loc 3", d, 8'h43);
    ce_off();

    // R7 full clock burst, control byte sets protect
    ce_on(); put_bits(8'hBE, 8);
    for (int i = 0; i < 7; i++) put_bits(8'h30 + 8'(i), 8);
    put_bits(8'h80, 8); ce_off();
    ce_on(); put_bits(8'hBF, 8);
    for (int i = 0; i < 8; i++) begin
      get_byte(d, ok);
      chk("R7 clock burst readback", d, (i == 7) ? 8'h80 : 8'h30 + 8'(i));
    end
    ce_off();
    rd1(0, 5'd8, d); chk("R7 location 8 untouched by burst", d, 8'hA5);

    // R7 burst write with protect set changes nothing
    ce_on(); put_bits(8'hBE, 8);
    for (int i = 0; i < 7; i++) put_bits(8'h50 + 8'(i), 8);
    put_bits(8'h00, 8); ce_off();
    rd1(0, 5'd7, d); chk("R7 protected burst keeps control", d, 8'h80);
    rd1(0, 5'd0, d); chk("R7 protected burst keeps loc 0", d, 8'h30);

    // R7 short burst changes nothing
    wr1(0, 5'd7, 8'h00);
    ce_on(); put_bits(8'hBE, 8);
    for (int i = 0; i < 5; i++) put_bits(8'h60 + 8'(i), 8);
    ce_off();
    rd1(0, 5'd0, d); chk("R7 short burst discarded", d, 8'h30);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule